// File: doc/BRIEF.md
# Extension Bus Master Cycle Generator

This block turns transfer requests into master cycles on a parallel extension bus. Two requesters feed it. A slave-side port forwards cycles taken from the host bus. A DMA port carries requests from a DMA engine. Each request names an address space, a data width and a cycle kind. The block first checks the combination. A legal request is driven onto the bus one beat at a time, and the block waits for the bus acknowledge on each beat. A 64-bit request is issued as two 32-bit beats.

Read data coming back from the bus carries one odd-parity bit per byte lane. The block checks only the lanes that the transfer uses. A parity failure reaches the two requesters in different ways. The slave-side requester gets a bus error together with its completion. A DMA request completes normally, and the failing beat address is latched into a sticky error status that a clear strobe resets. A request that breaks the rules ends one cycle after acceptance with an error response and never reaches the bus.

Top module: `xbus_master`

## Requirements
- R1: The encodings are: space 0 = A16, 1 = A24, 2 = A32, 3 = reserved; width 0 = D08, 1 = D16, 2 = D32, 3 = D64; type 0 = single, 1 = block, 2 = read-modify-write, 3 = synchronous burst. The following requests are illegal: reserved space, and in A16 space width D64, type block or type burst. Every other space, width and type combination is legal.
- R2: A burst request (type 3) from the slave-side port is illegal. The same request from the DMA port is legal.
- R3: An illegal request is answered in the cycle after acceptance. The slave-side port gets s_done with s_berr=1, and the DMA port gets d_done with d_err=1. No bus beat is driven.
- R4: A D64 request becomes two beats with bus_width=2 (D32). The first beat uses the request address and carries wdata[31:0]. The second beat uses that address plus 4 and carries wdata[63:32]. Read data from the two beats is returned as {second, first} on rsp_rdata.
- R5: A legal non-D64 request drives exactly one beat carrying the request's address, space, width, type, direction and low data word. The done pulse for the requester appears in the cycle after the acknowledged beat and lasts one cycle.
- R6: Read parity is odd over each byte lane plus its bit in bus_rpar. Lane i is bus_rdata[8i+7:8i]. Only active lanes are checked: D08 uses lane addr[1:0], D16 uses lanes 3:2 when addr[1]=1 and lanes 1:0 otherwise, and D32 and D64 use all four lanes.
- R7: A read parity error on any beat of a slave-side request raises s_berr together with s_done.
- R8: A read parity error on a DMA request completes with d_err=0. It sets err_valid and loads err_addr with the address of the first failing beat. While err_valid is set, later errors leave err_addr unchanged.
- R9: err_clr clears err_valid. If a new DMA parity error lands in the same cycle as err_clr, the new error wins: err_valid stays set and err_addr takes the new address.
- R10: When both ports request in the same cycle, the slave-side request is served first. The DMA request starts only after the slave-side request completes.
- R11: After reset, bus_valid, s_done, d_done and err_valid are all 0.
- R12: While bus_ack is low, the beat's address and write data are held on the bus, and the beat completes on the first cycle that has bus_ack high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave-side request, held until s_done |
| s_write | input | 1 | Slave-side direction, 1 = write |
| s_space | input | 2 | Slave-side address space |
| s_width | input | 2 | Slave-side data width |
| s_type | input | 2 | Slave-side cycle type |
| s_addr | input | ADDR_W | Slave-side address |
| s_wdata | input | 64 | Slave-side write data |
| s_done | output | 1 | Slave-side completion pulse |
| s_berr | output | 1 | Slave-side bus error, valid with s_done |
| d_req | input | 1 | DMA request, held until d_done |
| d_write | input | 1 | DMA direction, 1 = write |
| d_space | input | 2 | DMA address space |
| d_width | input | 2 | DMA data width |
| d_type | input | 2 | DMA cycle type |
| d_addr | input | ADDR_W | DMA address |
| d_wdata | input | 64 | DMA write data |
| d_done | output | 1 | DMA completion pulse |
| d_err | output | 1 | DMA illegal-request error, valid with d_done |
| rsp_rdata | output | 64 | Read data of the last completed request |
| bus_valid | output | 1 | Beat in progress |
| bus_write | output | 1 | Beat direction |
| bus_space | output | 2 | Beat address space |
| bus_width | output | 2 | Beat data width |
| bus_type | output | 2 | Beat cycle type |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 32 | Beat write data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | 32 | Beat read data |
| bus_rpar | input | 4 | Read parity, one odd bit per lane |
| err_clr | input | 1 | Clear strobe for the error status |
| err_valid | output | 1 | Sticky DMA parity error flag |
| err_addr | output | ADDR_W | Address of the first failing DMA beat |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a DMA parity error and the status clear strobe. The bench sets err_valid with an earlier error, then runs a second corrupted DMA read and raises err_clr so that it is high on exactly the edge where the failing beat completes. It passes when err_valid is still set and err_addr now holds the new address. The second pair is both request ports going active on the same edge. It passes when the first bus beat carries the slave-side address, the DMA beat follows only after s_done, and the two done pulses never overlap.

// File: rtl/xbus_master.sv
module xbus_master #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req,
  input  logic              s_write,
  input  logic [1:0]        s_space,
  input  logic [1:0]        s_width,
  input  logic [1:0]        s_type,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [63:0]       s_wdata,
  output logic              s_done,
  output logic              s_berr,
  input  logic              d_req,
  input  logic              d_write,
  input  logic [1:0]        d_space,
  input  logic [1:0]        d_width,
  input  logic [1:0]        d_type,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [63:0]       d_wdata,
  output logic              d_done,
  output logic              d_err,
  output logic [63:0]       rsp_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [1:0]        bus_space,
  output logic [1:0]        bus_width,
  output logic [1:0]        bus_type,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  input  logic [3:0]        bus_rpar,
  input  logic              err_clr,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr
);

  localparam logic [1:0] SP_A16 = 2'd0, SP_RSV = 2'd3;
  localparam logic [1:0] WD_D08 = 2'd0, WD_D16 = 2'd1, WD_D32 = 2'd2, WD_D64 = 2'd3;
  localparam logic [1:0] TY_BLK = 2'd1, TY_BST = 2'd3;
  localparam int LANES = 4;

  function automatic logic req_ok(input logic [1:0] sp, input logic [1:0] wd,
                                  input logic [1:0] ty, input logic from_s);
    logic bad;
    bad = (sp == SP_RSV) ||
          ((sp == SP_A16) && ((wd == WD_D64) || (ty == TY_BLK) || (ty == TY_BST))) ||
          (from_s && (ty == TY_BST));
    return !bad;
  endfunction

  logic              busy, beat, src_s, r_write, perr;
  logic [1:0]        r_space, r_width, r_type;
  logic [ADDR_W-1:0] r_addr, pend_addr;
  logic [63:0]       r_wdata;

  wire              take   = (s_req || d_req) && !busy && !s_done && !d_done;
  wire              pick_s = s_req;
  wire [1:0]        n_space = pick_s ? s_space : d_space;
  wire [1:0]        n_width = pick_s ? s_width : d_width;
  wire [1:0]        n_type  = pick_s ? s_type  : d_type;
  wire              n_ok    = req_ok(n_space, n_width, n_type, pick_s);

  assign bus_valid = busy;
  assign bus_write = r_write;
  assign bus_space = r_space;
  assign bus_type  = r_type;
  assign bus_width = (r_width == WD_D64) ? WD_D32 : r_width;
  assign bus_addr  = beat ? r_addr + ADDR_W'(4) : r_addr;
  assign bus_wdata = beat ? r_wdata[63:32] : r_wdata[31:0];

  logic [LANES-1:0] lanes, lane_odd;
  always_comb begin
    case (r_width)
      WD_D08:  lanes = 4'b0001 << r_addr[1:0];
      WD_D16:  lanes = r_addr[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_par
    assign lane_odd[i] = ^{bus_rdata[8*i +: 8], bus_rpar[i]};
  end

  wire              beat_perr = !r_write && |(lanes & ~lane_odd);
  wire              perr_any  = perr || beat_perr;
  wire [ADDR_W-1:0] fail_addr = perr ? pend_addr : bus_addr;
  wire              last_beat = (r_width != WD_D64) || beat;
  wire              beat_end  = busy && bus_ack;
  wire              err_set   = beat_end && last_beat && !src_s && perr_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat      <= 1'b0;
      src_s     <= 1'b0;
      r_write   <= 1'b0;
      r_space   <= '0;
      r_width   <= '0;
      r_type    <= '0;
      r_addr    <= '0;
      r_wdata   <= '0;
      perr      <= 1'b0;
      pend_addr <= '0;
      s_done    <= 1'b0;
      s_berr    <= 1'b0;
      d_done    <= 1'b0;
      d_err     <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      s_done <= 1'b0;
      s_berr <= 1'b0;
      d_done <= 1'b0;
      d_err  <= 1'b0;
      if (take) begin
        if (!n_ok) begin
          s_done <= pick_s;
          s_berr <= pick_s;
          d_done <= !pick_s;
          d_err  <= !pick_s;
        end else begin
          busy    <= 1'b1;
          beat    <= 1'b0;
          perr    <= 1'b0;
          src_s   <= pick_s;
          r_write <= pick_s ? s_write : d_write;
          r_space <= n_space;
          r_width <= n_width;
          r_type  <= n_type;
          r_addr  <= pick_s ? s_addr  : d_addr;
          r_wdata <= pick_s ? s_wdata : d_wdata;
        end
      end else if (beat_end) begin
        if (!r_write) begin
          if (beat) rsp_rdata[63:32] <= bus_rdata;
          else      rsp_rdata        <= {32'h0, bus_rdata};
        end
        if (last_beat) begin
          busy   <= 1'b0;
          beat   <= 1'b0;
          s_done <= src_s;
          s_berr <= src_s && perr_any;
          d_done <= !src_s;
        end else begin
          beat      <= 1'b1;
          perr      <= perr_any;
          pend_addr <= fail_addr;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
    end else if (err_set && (!err_valid || err_clr)) begin
      err_valid <= 1'b1;
      err_addr  <= fail_addr;
    end else if (err_clr) begin
      err_valid <= 1'b0;
    end
  end

endmodule

module xbus_master_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_done,
  input logic              s_berr,
  input logic              d_done,
  input logic              d_err,
  input logic              bus_valid,
  input logic [1:0]        bus_space,
  input logic [1:0]        bus_width,
  input logic [1:0]        bus_type,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              err_clr,
  input logic              err_valid
);

  assert_legal_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_space != 2'd3) &&
                  !((bus_space == 2'd0) && ((bus_type == 2'd1) || (bus_type == 2'd3))));

  assert_beat_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_width != 2'd3);

  assert_hold_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata));

  assert_done_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_done && d_done));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |=> !s_done);

  assert_berr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_berr |-> s_done);

  assert_derr_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    d_err |-> d_done);

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !err_clr |=> err_valid);

endmodule

bind xbus_master xbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_done(s_done), .s_berr(s_berr),
  .d_done(d_done), .d_err(d_err), .bus_valid(bus_valid),
  .bus_space(bus_space), .bus_width(bus_width), .bus_type(bus_type),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .err_clr(err_clr), .err_valid(err_valid)
);

// File: tb/xbus_master_tb.sv
`timescale 1ns/1ps
module xbus_master_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          s_req = 0, s_write = 0, d_req = 0, d_write = 0;
  logic [1:0]    s_space = 0, s_width = 0, s_type = 0;
  logic [1:0]    d_space = 0, d_width = 0, d_type = 0;
  logic [AW-1:0] s_addr = 0, d_addr = 0;
  logic [63:0]   s_wdata = 0, d_wdata = 0;
  logic          s_done, s_berr, d_done, d_err;
  logic [63:0]   rsp_rdata;
  logic          bus_valid, bus_write;
  logic [1:0]    bus_space, bus_width, bus_type;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_ack = 0;
  logic [31:0]   bus_rdata = 0;
  logic [3:0]    bus_rpar = 0;
  logic          err_clr = 0;
  logic          err_valid;
  logic [AW-1:0] err_addr;

  xbus_master #(.ADDR_W(AW)) u_dut (.*);

  int checks = 0, errors = 0;
  int nbeats = 0, wcnt = 0, ack_delay = 0;
  logic [31:0] log_addr [0:7];
  logic [31:0] log_wdata[0:7];
  logic [1:0]  log_width[0:7];
  logic [31:0] rd_word  [0:7];
  logic [3:0]  bad_mask [0:7];
  logic        got_err;
  logic [63:0] got_rdata;
  int          got_cyc;

  function automatic logic [3:0] gen_par(input logic [31:0] w);
    for (int i = 0; i < 4; i++) gen_par[i] = ~^w[8*i +: 8];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || !bus_valid) begin
      bus_ack = 0;
      wcnt = 0;
    end else if (wcnt < ack_delay) begin
      wcnt++;
      bus_ack = 0;
    end else begin
      wcnt = 0;
      if (nbeats < 8) begin
        log_addr[nbeats]  = bus_addr;
        log_wdata[nbeats] = bus_wdata;
        log_width[nbeats] = bus_width;
        bus_rdata = rd_word[nbeats];
        bus_rpar  = gen_par(rd_word[nbeats]) ^ bad_mask[nbeats];
      end
      nbeats++;
      bus_ack = 1;
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clear_rd();
    for (int i = 0; i < 8; i++) begin
      rd_word[i] = 32'h0;
      bad_mask[i] = 4'h0;
    end
    nbeats = 0;
  endtask

  task automatic run(input bit from_s, input bit wr, input logic [1:0] sp,
                     input logic [1:0] wd, input logic [1:0] ty,
                     input logic [31:0] a, input logic [63:0] wdat);
    nbeats = 0;
    @(negedge clk);
    if (from_s) begin
      s_write = wr; s_space = sp; s_width = wd; s_type = ty; s_addr = a; s_wdata = wdat; s_req = 1;
    end else begin
      d_write = wr; d_space = sp; d_width = wd; d_type = ty; d_addr = a; d_wdata = wdat; d_req = 1;
    end
    got_cyc = 0;
    forever begin
      @(negedge clk);
      got_cyc++;
      if ((from_s && s_done) || (!from_s && d_done) || got_cyc > 60) break;
    end
    got_err   = from_s ? s_berr : d_err;
    got_rdata = rsp_rdata;
    s_req = 0;
    d_req = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 bus_valid", bus_valid, 0);
    check("R11 s_done", s_done, 0);
    check("R11 d_done", d_done, 0);
    check("R11 err_valid", err_valid, 0);
  endtask

  task automatic t_single();
    clear_rd();
    run(1, 1, 2'd1, 2'd2, 2'd0, 32'h0012_3450, 64'h1111_2222_A5A5_5A5A);
    check("R5 beats", nbeats, 1);
    check("R5 addr", log_addr[0], 32'h0012_3450);
    check("R5 wdata", log_wdata[0], 32'hA5A5_5A5A);
    check("R5 width", log_width[0], 2'd2);
    check("R5 berr", got_err, 0);
    check("R5 latency", got_cyc, 2);
  endtask

  task automatic t_d64();
    clear_rd();
    run(1, 1, 2'd2, 2'd3, 2'd1, 32'h8000_0100, 64'hDEAD_BEEF_0BAD_F00D);
    check("R4 wr beats", nbeats, 2);
    check("R4 wr addr0", log_addr[0], 32'h8000_0100);
    check("R4 wr addr1", log_addr[1], 32'h8000_0104);
    check("R4 wr data0", log_wdata[0], 32'h0BAD_F00D);
    check("R4 wr data1", log_wdata[1], 32'hDEAD_BEEF);
    check("R4 width1", log_width[1], 2'd2);
    clear_rd();
    rd_word[0] = 32'h7654_3210;
    rd_word[1] = 32'hFEDC_BA98;
    run(1, 0, 2'd2, 2'd3, 2'd0, 32'h0000_2000, 64'h0);
    check("R4 rd beats", nbeats, 2);
    check("R4 rd data", got_rdata, 64'hFEDC_BA98_7654_3210);
    check("R4 rd berr", got_err, 0);
  endtask

  task automatic t_illegal();
    clear_rd();
    run(1, 0, 2'd0, 2'd3, 2'd0, 32'h0000_0010, 64'h0);
    check("R1 A16 D64 berr", got_err, 1);
    check("R3 A16 D64 beats", nbeats, 0);
    check("R3 latency", got_cyc, 1);
    run(0, 1, 2'd0, 2'd2, 2'd1, 32'h0000_0020, 64'h0);
    check("R1 A16 block d_err", got_err, 1);
    check("R3 A16 block beats", nbeats, 0);
    run(0, 1, 2'd3, 2'd2, 2'd0, 32'h0000_0030, 64'h0);
    check("R1 reserved space d_err", got_err, 1);
    run(1, 1, 2'd0, 2'd1, 2'd2, 32'h0000_0040, 64'h0);
    check("R1 A16 RMW D16 legal", got_err, 0);
    check("R1 A16 RMW beats", nbeats, 1);
    run(1, 1, 2'd2, 2'd2, 2'd3, 32'h0000_0050, 64'h0);
    check("R2 slave burst berr", got_err, 1);
    check("R2 slave burst beats", nbeats, 0);
    run(0, 1, 2'd2, 2'd2, 2'd3, 32'h0000_0060, 64'h0);
    check("R2 dma burst d_err", got_err, 0);
    check("R2 dma burst beats", nbeats, 1);
  endtask

  task automatic t_lanes();
    clear_rd();
    rd_word[0] = 32'h00C3_0000;
    bad_mask[0] = 4'b0001;
    run(1, 0, 2'd1, 2'd0, 2'd0, 32'h0000_0102, 64'h0);
    check("R6 D08 inactive lane ignored", got_err, 0);
    clear_rd();
    rd_word[0] = 32'h00C3_0000;
    bad_mask[0] = 4'b0100;
    run(1, 0, 2'd1, 2'd0, 2'd0, 32'h0000_0102, 64'h0);
    check("R7 D08 active lane berr", got_err, 1);
    clear_rd();
    rd_word[0] = 32'h1234_0000;
    bad_mask[0] = 4'b0010;
    run(1, 0, 2'd2, 2'd1, 2'd0, 32'h0000_0202, 64'h0);
    check("R6 D16 high half ignores lane1", got_err, 0);
    clear_rd();
    rd_word[1] = 32'h0000_00FF;
    bad_mask[1] = 4'b1000;
    run(1, 0, 2'd2, 2'd3, 2'd0, 32'h0000_0300, 64'h0);
    check("R7 D64 second beat berr", got_err, 1);
  endtask

  task automatic t_dma_err();
    clear_rd();
    bad_mask[1] = 4'b0100;
    run(0, 0, 2'd2, 2'd3, 2'd0, 32'h4000_0040, 64'h0);
    check("R8 d_err low", got_err, 0);
    check("R8 err_valid", err_valid, 1);
    check("R8 err_addr", err_addr, 32'h4000_0044);
    clear_rd();
    bad_mask[0] = 4'b0001;
    run(0, 0, 2'd1, 2'd2, 2'd0, 32'h0000_0800, 64'h0);
    check("R8 sticky addr", err_addr, 32'h4000_0044);
    check("R8 sticky flag", err_valid, 1);
  endtask

  task automatic t_clear_collide();
    clear_rd();
    bad_mask[0] = 4'b1000;
    @(negedge clk);
    d_write = 0; d_space = 2'd2; d_width = 2'd2; d_type = 2'd0;
    d_addr = 32'h0000_0C00; d_req = 1;
    @(negedge clk);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    check("R9 collide done", d_done, 1);
    d_req = 0;
    check("R9 collide flag", err_valid, 1);
    check("R9 collide addr", err_addr, 32'h0000_0C00);
    @(negedge clk);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    check("R9 plain clear", err_valid, 0);
  endtask

  task automatic t_priority();
    int s_at, d_at, cyc;
    clear_rd();
    @(negedge clk);
    s_write = 1; s_space = 2'd1; s_width = 2'd2; s_type = 2'd0; s_addr = 32'h0000_AAA0; s_req = 1;
    d_write = 1; d_space = 2'd1; d_width = 2'd2; d_type = 2'd0; d_addr = 32'h0000_BBB0; d_req = 1;
    s_at = 0; d_at = 0; cyc = 0;
    while ((d_at == 0) && (cyc < 60)) begin
      @(negedge clk);
      cyc++;
      if (s_done) begin s_at = cyc; s_req = 0; end
      if (d_done) begin d_at = cyc; d_req = 0; end
    end
    check("R10 beats", nbeats, 2);
    check("R10 first beat slave", log_addr[0], 32'h0000_AAA0);
    check("R10 second beat dma", log_addr[1], 32'h0000_BBB0);
    check("R10 slave done first", (s_at > 0) && (s_at < d_at), 1);
    @(negedge clk);
  endtask

  task automatic t_stall();
    clear_rd();
    ack_delay = 3;
    run(0, 1, 2'd2, 2'd2, 2'd2, 32'h0000_5550, 64'h0000_0000_CAFE_F00D);
    ack_delay = 0;
    check("R12 stalled beats", nbeats, 1);
    check("R12 stalled addr", log_addr[0], 32'h0000_5550);
    check("R12 stalled data", log_wdata[0], 32'hCAFE_F00D);
    check("R12 stalled latency", got_cyc, 5);
  endtask

  initial begin
    clear_rd();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_d64();
    t_illegal();
    t_lanes();
    t_dma_err();
    t_clear_collide();
    t_priority();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule